// File: doc/BRIEF.md
# Indirect Auto-Increment Address Stage

This pipeline stage sits between decode and execute in a core built around 12-bit words. It turns an instruction's memory operand into its final 15-bit address. When the operand is indirect, the stage reads a pointer word from the data cache at the instruction's initial address. On a miss it requests one line fill and holds the instruction until the line arrives. When the pointer location auto-increments, the stage writes the incremented pointer back as a single-word masked store. That same store is mirrored to both caches as an opportunistic update. The final address joins a 3-bit field selector with the resulting pointer.

Instructions carry a generation tag. An instruction is live when its tag equals the stage's own generation or the core's generation. Any other tag marks it as squashed. A flush pulse moves the stage's generation to the core's current value. A resolved instruction still waiting in the output register keeps its old tag, so a flush squashes it. If that instruction had already incremented its pointer, the stage issues a compensating store that writes back the previous pointer value. A counter of completed stores advances by one when an auto-increment instruction is handed on. It advances by two when such an instruction is undone.

Top module: `ind_autoinc_stage`

## Requirements
- R1: After reset, `out_valid_o`, `st_valid_o`, `fill_valid_o` and `upd_valid_o` are low and `store_cnt_o` is zero.
- R2: A live instruction with `in_ind_i` low is accepted whenever the output register can take it. It leaves one cycle later with `out_addr_o` equal to `in_addr_i`, and it raises no fill or store, whatever `in_inc_i` holds.
- R3: A live indirect instruction without auto-increment that hits in the cache leaves with `out_addr_o = {in_df_i, dc_data_i}`.
- R4: A live indirect instruction that misses raises `fill_valid_o` with `fill_line_o = in_addr_i >> log2(LINE_WORDS)` and holds `in_ready_o` low. Once a fill has been accepted, no further fill is requested for that instruction.
- R5: A live indirect auto-increment hit raises a store to `in_addr_i`. The store data is `(dc_data_i + 1) mod 4096`, so 12'o7777 wraps to 0. `st_mask_o` has only bit `in_addr_i[2:0]` set (with `LINE_WORDS` = 8). The final address uses the incremented pointer.
- R6: While an auto-increment store cannot be issued (`st_ready_i` low), `in_ready_o` stays low and nothing enters the output register.
- R7: A head instruction whose tag matches neither generation is consumed with `in_ready_o` high. It raises no fill or store and never appears at the output.
- R8: An instruction tagged with the stage generation stays live when the core generation differs. Accepting an instruction tagged with the core generation moves the stage generation to it, and from then on older tags are squashed.
- R9: After a flush, an auto-increment instruction held in the output register is withdrawn (`out_valid_o` low). A store of `(final pointer - 1) mod 4096` to its initial address is raised and held until `st_ready_i` is high. When it completes, `store_cnt_o` rises by 2.
- R10: `store_cnt_o` rises by 1 when an auto-increment instruction is taken at the output.
- R11: Every completed store, whether auto-increment or undo, shows on `upd_valid_o` in the same cycle with the same address and data.
- R12: While `out_valid_o` is high and `out_ready_i` is low, the output fields hold and no new instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Resynchronise stage generation to `core_gen_i` |
| core_gen_i | input | GEN_W | Core's current generation |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Instruction consumed (advanced or squashed) |
| in_gen_i | input | GEN_W | Instruction generation tag |
| in_ind_i | input | 1 | Operand is indirect |
| in_inc_i | input | 1 | Pointer location auto-increments |
| in_addr_i | input | ADDR_W | Initial address |
| in_df_i | input | FIELD_W | Field selector for the final address |
| dc_addr_o | output | ADDR_W | Data cache lookup address |
| dc_hit_i | input | 1 | Lookup hit |
| dc_data_i | input | WORD_W | Pointer word on hit |
| fill_valid_o | output | 1 | Line fill request |
| fill_ready_i | input | 1 | Fill channel ready |
| fill_line_o | output | ADDR_W-LINE_W | Line address to fill |
| st_valid_o | output | 1 | Store request |
| st_ready_i | input | 1 | Store channel ready |
| st_addr_o | output | ADDR_W | Store word address |
| st_data_o | output | WORD_W | Store data |
| st_mask_o | output | LINE_WORDS | One-hot word mask within the line |
| upd_valid_o | output | 1 | Opportunistic update to both caches |
| upd_addr_o | output | ADDR_W | Update address |
| upd_data_o | output | WORD_W | Update data |
| out_valid_o | output | 1 | Resolved instruction valid |
| out_ready_i | input | 1 | Downstream ready |
| out_gen_o | output | GEN_W | Resolved instruction tag |
| out_addr_o | output | ADDR_W | Final address |
| out_inc_o | output | 1 | Instruction performed an auto-increment |
| store_cnt_o | output | CNT_W | Completed-store count |

## Verification
The assertions rely on three things about the inputs. The cache answers a lookup in the same cycle. The core generation changes only together with or ahead of a flush. The instruction at the head does not change while `in_ready_o` is low. The stimulus changes inputs only on falling edges. It keeps each instruction in place until it is consumed. It raises the core generation only while the output register holds an instruction whose tag the assertions treat as live or withdrawn, never in the middle of a handshake.

// File: rtl/ind_stage_pkg.sv
package ind_stage_pkg;
  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_INC  = 2'd1,
    ST_UNDO = 2'd2
  } st_src_e;
endpackage

// File: rtl/ind_gen_track.sv
module ind_gen_track #(
  parameter int GEN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             adopt_i,
  input  logic [GEN_W-1:0] core_gen_i,
  input  logic [GEN_W-1:0] head_gen_i,
  input  logic [GEN_W-1:0] slot_gen_i,
  output logic [GEN_W-1:0] stage_gen_o,
  output logic             head_live_o,
  output logic             slot_live_o
);
  logic [GEN_W-1:0] stage_gen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  stage_gen_q <= '0;
    else if (flush_i || adopt_i)  stage_gen_q <= core_gen_i;
  end

  // equality only: tags may be Gray-coded upstream
  assign head_live_o = (head_gen_i == stage_gen_q) || (head_gen_i == core_gen_i);
  assign slot_live_o = (slot_gen_i == stage_gen_q) || (slot_gen_i == core_gen_i);
  assign stage_gen_o = stage_gen_q;
endmodule

// File: rtl/ind_resolve.sv
module ind_resolve #(
  parameter int WORD_W     = 12,
  parameter int FIELD_W    = 3,
  parameter int LINE_WORDS = 8,
  localparam int ADDR_W    = WORD_W + FIELD_W,
  localparam int LINE_W    = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              live_i,
  input  logic              ind_i,
  input  logic              inc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FIELD_W-1:0] df_i,
  input  logic              hit_i,
  input  logic [WORD_W-1:0] ptr_i,
  input  logic              space_i,
  input  logic              st_free_i,
  input  logic              st_ready_i,
  input  logic              fill_ready_i,
  output logic              fill_valid_o,
  output logic [ADDR_W-LINE_W-1:0] fill_line_o,
  output logic              inc_req_o,
  output logic [WORD_W-1:0] new_ptr_o,
  output logic [ADDR_W-1:0] final_o,
  output logic              advance_o,
  output logic              consume_o
);
  logic              head_ok;
  logic              miss;
  logic              mem_ok;
  logic              fill_sent_q;
  logic [WORD_W-1:0] ptr_inc;

  assign head_ok = valid_i && live_i;
  assign ptr_inc = ptr_i + WORD_W'(1);
  assign new_ptr_o = inc_i ? ptr_inc : ptr_i;
  assign final_o = ind_i ? {df_i, new_ptr_o} : addr_i;

  assign miss         = head_ok && ind_i && !hit_i;
  assign fill_valid_o = miss && !fill_sent_q;
  assign fill_line_o  = addr_i[ADDR_W-1:LINE_W];

  assign inc_req_o = head_ok && ind_i && hit_i && inc_i && space_i && st_free_i;
  assign mem_ok    = !ind_i || (hit_i && (!inc_i || (st_free_i && st_ready_i)));
  assign advance_o = head_ok && space_i && mem_ok;
  assign consume_o = (valid_i && !live_i) || advance_o;

  // one fill per miss episode; rearmed when the head leaves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            fill_sent_q <= 1'b0;
    else if (consume_o)                     fill_sent_q <= 1'b0;
    else if (fill_valid_o && fill_ready_i)  fill_sent_q <= 1'b1;
  end
endmodule

// File: rtl/ind_slot.sv
module ind_slot #(
  parameter int ADDR_W = 15,
  parameter int GEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [GEN_W-1:0]  gen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] init_i,
  input  logic              inc_i,
  input  logic              live_i,
  input  logic              out_ready_i,
  input  logic              undo_done_i,
  output logic [GEN_W-1:0]  gen_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] init_o,
  output logic              inc_o,
  output logic              out_valid_o,
  output logic              out_fire_o,
  output logic              undo_req_o,
  output logic              space_o
);
  logic v_q;
  logic drop;

  assign out_valid_o = v_q && live_i;
  assign out_fire_o  = out_valid_o && out_ready_i;
  assign undo_req_o  = v_q && !live_i && inc_o;
  assign drop        = v_q && !live_i && !inc_o;
  assign space_o     = !v_q || out_fire_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      gen_o  <= '0;
      addr_o <= '0;
      init_o <= '0;
      inc_o  <= 1'b0;
    end else if (load_i) begin
      v_q    <= 1'b1;
      gen_o  <= gen_i;
      addr_o <= addr_i;
      init_o <= init_i;
      inc_o  <= inc_i;
    end else if (out_fire_o || undo_done_i || drop) begin
      v_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/ind_autoinc_stage.sv
module ind_autoinc_stage
  import ind_stage_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int FIELD_W    = 3,
  parameter int LINE_WORDS = 8,
  parameter int GEN_W      = 2,
  parameter int CNT_W      = 16,
  localparam int ADDR_W    = WORD_W + FIELD_W,
  localparam int LINE_W    = $clog2(LINE_WORDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [GEN_W-1:0]         core_gen_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [GEN_W-1:0]         in_gen_i,
  input  logic                     in_ind_i,
  input  logic                     in_inc_i,
  input  logic [ADDR_W-1:0]        in_addr_i,
  input  logic [FIELD_W-1:0]       in_df_i,
  output logic [ADDR_W-1:0]        dc_addr_o,
  input  logic                     dc_hit_i,
  input  logic [WORD_W-1:0]        dc_data_i,
  output logic                     fill_valid_o,
  input  logic                     fill_ready_i,
  output logic [ADDR_W-LINE_W-1:0] fill_line_o,
  output logic                     st_valid_o,
  input  logic                     st_ready_i,
  output logic [ADDR_W-1:0]        st_addr_o,
  output logic [WORD_W-1:0]        st_data_o,
  output logic [LINE_WORDS-1:0]    st_mask_o,
  output logic                     upd_valid_o,
  output logic [ADDR_W-1:0]        upd_addr_o,
  output logic [WORD_W-1:0]        upd_data_o,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [GEN_W-1:0]         out_gen_o,
  output logic [ADDR_W-1:0]        out_addr_o,
  output logic                     out_inc_o,
  output logic [CNT_W-1:0]         store_cnt_o
);
  logic [GEN_W-1:0]  stage_gen;
  logic              head_live, slot_live;
  logic              adopt;
  logic              inc_req, advance, consume;
  logic [WORD_W-1:0] new_ptr;
  logic [ADDR_W-1:0] final_addr;
  logic [ADDR_W-1:0] slot_init;
  logic              out_fire, undo_req, undo_done, space;
  st_src_e           st_src;
  logic              st_fire;
  logic [CNT_W-1:0]  cnt_q;

  assign dc_addr_o = in_addr_i;
  assign adopt     = advance && (in_gen_i == core_gen_i);

  ind_gen_track #(.GEN_W(GEN_W)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .adopt_i     (adopt),
    .core_gen_i  (core_gen_i),
    .head_gen_i  (in_gen_i),
    .slot_gen_i  (out_gen_o),
    .stage_gen_o (stage_gen),
    .head_live_o (head_live),
    .slot_live_o (slot_live)
  );

  ind_resolve #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .LINE_WORDS(LINE_WORDS)) u_res (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (in_valid_i),
    .live_i       (head_live),
    .ind_i        (in_ind_i),
    .inc_i        (in_inc_i),
    .addr_i       (in_addr_i),
    .df_i         (in_df_i),
    .hit_i        (dc_hit_i),
    .ptr_i        (dc_data_i),
    .space_i      (space),
    .st_free_i    (!undo_req),
    .st_ready_i   (st_ready_i),
    .fill_ready_i (fill_ready_i),
    .fill_valid_o (fill_valid_o),
    .fill_line_o  (fill_line_o),
    .inc_req_o    (inc_req),
    .new_ptr_o    (new_ptr),
    .final_o      (final_addr),
    .advance_o    (advance),
    .consume_o    (consume)
  );

  ind_slot #(.ADDR_W(ADDR_W), .GEN_W(GEN_W)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (advance),
    .gen_i       (in_gen_i),
    .addr_i      (final_addr),
    .init_i      (in_addr_i),
    .inc_i       (in_ind_i && in_inc_i),
    .live_i      (slot_live),
    .out_ready_i (out_ready_i),
    .undo_done_i (undo_done),
    .gen_o       (out_gen_o),
    .addr_o      (out_addr_o),
    .init_o      (slot_init),
    .inc_o       (out_inc_o),
    .out_valid_o (out_valid_o),
    .out_fire_o  (out_fire),
    .undo_req_o  (undo_req),
    .space_o     (space)
  );

  assign in_ready_o = consume;

  // undo owns the store channel first: the slot cannot drain otherwise
  always_comb begin
    if (undo_req)     st_src = ST_UNDO;
    else if (inc_req) st_src = ST_INC;
    else              st_src = ST_NONE;
  end

  always_comb begin
    unique case (st_src)
      ST_UNDO: begin
        st_addr_o = slot_init;
        st_data_o = out_addr_o[WORD_W-1:0] - WORD_W'(1);
      end
      ST_INC: begin
        st_addr_o = in_addr_i;
        st_data_o = new_ptr;
      end
      default: begin
        st_addr_o = in_addr_i;
        st_data_o = new_ptr;
      end
    endcase
  end

  assign st_valid_o = (st_src != ST_NONE);
  assign st_fire    = st_valid_o && st_ready_i;
  assign undo_done  = (st_src == ST_UNDO) && st_ready_i;

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_mask
    assign st_mask_o[g] = (st_addr_o[LINE_W-1:0] == LINE_W'(g));
  end

  assign upd_valid_o = st_fire;
  assign upd_addr_o  = st_addr_o;
  assign upd_data_o  = st_data_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (undo_done)              cnt_q <= cnt_q + CNT_W'(2);
    else if (out_fire && out_inc_o)  cnt_q <= cnt_q + CNT_W'(1);
  end
  assign store_cnt_o = cnt_q;
endmodule

// File: rtl/ind_stage_chk.sv
module ind_stage_chk #(
  parameter int ADDR_W     = 15,
  parameter int LINE_WORDS = 8,
  parameter int GEN_W      = 2,
  parameter int CNT_W      = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic                  in_ready_o,
  input logic                  in_ind_i,
  input logic                  head_live,
  input logic                  dc_hit_i,
  input logic                  fill_valid_o,
  input logic                  st_valid_o,
  input logic [LINE_WORDS-1:0] st_mask_o,
  input logic                  out_valid_o,
  input logic                  out_ready_i,
  input logic [ADDR_W-1:0]     out_addr_o,
  input logic [GEN_W-1:0]      out_gen_o,
  input logic [GEN_W-1:0]      stage_gen,
  input logic [GEN_W-1:0]      core_gen_i,
  input logic [CNT_W-1:0]      store_cnt_o
);
  p_fill_on_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> (in_valid_i && in_ind_i && !dc_hit_i && !in_ready_o));

  p_ind_needs_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_ind_i && head_live) |-> dc_hit_i);

  p_mask_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |-> ($countones(st_mask_o) == 1));

  p_out_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_gen_o == stage_gen) || (out_gen_o == core_gen_i)));

  p_cnt_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_cnt_o - $past(store_cnt_o)) <= CNT_W'(2));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> $stable(out_addr_o));
endmodule

bind ind_autoinc_stage ind_stage_chk #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .GEN_W(GEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .in_ind_i     (in_ind_i),
  .head_live    (head_live),
  .dc_hit_i     (dc_hit_i),
  .fill_valid_o (fill_valid_o),
  .st_valid_o   (st_valid_o),
  .st_mask_o    (st_mask_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_addr_o   (out_addr_o),
  .out_gen_o    (out_gen_o),
  .stage_gen    (stage_gen),
  .core_gen_i   (core_gen_i),
  .store_cnt_o  (store_cnt_o)
);

// File: tb/ind_autoinc_stage_tb.sv
module ind_autoinc_stage_tb;
  localparam int WORD_W = 12;
  localparam int FIELD_W = 3;
  localparam int LINE_WORDS = 8;
  localparam int GEN_W = 2;
  localparam int CNT_W = 16;
  localparam int ADDR_W = WORD_W + FIELD_W;
  localparam int LINE_W = $clog2(LINE_WORDS);

  typedef struct packed {
    logic              ind;
    logic              inc;
    logic [ADDR_W-1:0] init;
    logic [FIELD_W-1:0] df;
    logic [WORD_W-1:0] ptr;
    logic [ADDR_W-1:0] exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 15'o12345, 3'd0, 12'o0000, 15'o12345},
    '{1'b1, 1'b0, 15'o00100, 3'd3, 12'o1234, 15'o31234},
    '{1'b1, 1'b1, 15'o00012, 3'd5, 12'o0777, 15'o51000},
    '{1'b1, 1'b1, 15'o00017, 3'd7, 12'o7777, 15'o70000},
    '{1'b1, 1'b0, 15'o70007, 3'd0, 12'o0000, 15'o00000},
    '{1'b1, 1'b1, 15'o00013, 3'd1, 12'o4321, 15'o14322}
  };

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [GEN_W-1:0] core_gen = '0, in_gen = '0;
  logic in_valid = 1'b0, in_ind = 1'b0, in_inc = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [FIELD_W-1:0] in_df = '0;
  logic dc_hit = 1'b0;
  logic [WORD_W-1:0] dc_data = '0;
  logic fill_ready = 1'b1, st_ready = 1'b1, out_ready = 1'b1;

  logic in_ready, fill_valid, st_valid, upd_valid, out_valid, out_inc;
  logic [ADDR_W-1:0] dc_addr, st_addr, upd_addr, out_addr;
  logic [ADDR_W-LINE_W-1:0] fill_line;
  logic [WORD_W-1:0] st_data, upd_data;
  logic [LINE_WORDS-1:0] st_mask;
  logic [GEN_W-1:0] out_gen;
  logic [CNT_W-1:0] store_cnt;

  int errors = 0, checks = 0, exp_cnt = 0;

  always #5 clk = ~clk;

  ind_autoinc_stage u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .core_gen_i(core_gen),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_gen_i(in_gen),
    .in_ind_i(in_ind), .in_inc_i(in_inc), .in_addr_i(in_addr), .in_df_i(in_df),
    .dc_addr_o(dc_addr), .dc_hit_i(dc_hit), .dc_data_i(dc_data),
    .fill_valid_o(fill_valid), .fill_ready_i(fill_ready), .fill_line_o(fill_line),
    .st_valid_o(st_valid), .st_ready_i(st_ready), .st_addr_o(st_addr),
    .st_data_o(st_data), .st_mask_o(st_mask),
    .upd_valid_o(upd_valid), .upd_addr_o(upd_addr), .upd_data_o(upd_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_gen_o(out_gen),
    .out_addr_o(out_addr), .out_inc_o(out_inc), .store_cnt_o(store_cnt)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [GEN_W-1:0] g, input logic ind, input logic inc,
                     input logic [ADDR_W-1:0] a, input logic [FIELD_W-1:0] df,
                     input logic hit, input logic [WORD_W-1:0] ptr);
    in_valid = 1'b1; in_gen = g; in_ind = ind; in_inc = inc;
    in_addr = a; in_df = df; dc_hit = hit; dc_data = ptr;
  endtask

  task automatic after_edge();
    @(posedge clk); #2;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3;
    chk("R1", "out_valid in reset", 32'(out_valid), 0);
    chk("R1", "st_valid in reset", 32'(st_valid), 0);
    chk("R1", "fill_valid in reset", 32'(fill_valid), 0);
    chk("R1", "upd_valid in reset", 32'(upd_valid), 0);
    chk("R1", "store_cnt in reset", 32'(store_cnt), 0);
    #20 rst_n = 1'b1;
    after_edge();
    chk("R1", "out_valid after reset", 32'(out_valid), 0);

    // table walk: R2 / R3 / R5 / R10 / R11
    for (int v = 0; v < NV; v++) begin
      string tag;
      logic exp_st;
      tag = VECS[v].ind ? (VECS[v].inc ? "R5" : "R3") : "R2";
      exp_st = VECS[v].ind && VECS[v].inc;
      @(negedge clk);
      put('0, VECS[v].ind, VECS[v].inc, VECS[v].init, VECS[v].df, 1'b1, VECS[v].ptr);
      #1;
      chk(tag, "in_ready", 32'(in_ready), 1);
      chk(tag, "fill_valid", 32'(fill_valid), 0);
      chk(tag, "st_valid", 32'(st_valid), 32'(exp_st));
      if (exp_st) begin
        chk("R5", "st_addr", 32'(st_addr), 32'(VECS[v].init));
        chk("R5", "st_data", 32'(st_data), 32'(VECS[v].exp[WORD_W-1:0]));
        chk("R5", "st_mask", 32'(st_mask), 32'(1) << VECS[v].init[LINE_W-1:0]);
        chk("R11", "upd_valid", 32'(upd_valid), 1);
        chk("R11", "upd_addr", 32'(upd_addr), 32'(VECS[v].init));
        chk("R11", "upd_data", 32'(upd_data), 32'(VECS[v].exp[WORD_W-1:0]));
      end
      after_edge();
      chk(tag, "out_valid", 32'(out_valid), 1);
      chk(tag, "out_addr", 32'(out_addr), 32'(VECS[v].exp));
      @(negedge clk);
      in_valid = 1'b0;
      after_edge();
      if (exp_st) exp_cnt++;
      chk("R10", "store_cnt", 32'(store_cnt), 32'(exp_cnt));
      chk(tag, "drained", 32'(out_valid), 0);
    end

    // R4: miss, one fill, then hit
    @(negedge clk);
    put('0, 1'b1, 1'b0, 15'o00123, 3'd6, 1'b0, '0);
    fill_ready = 1'b0;
    #1;
    chk("R4", "fill_valid", 32'(fill_valid), 1);
    chk("R4", "fill_line", 32'(fill_line), 32'(12'o0012));
    chk("R4", "in_ready", 32'(in_ready), 0);
    after_edge();
    chk("R4", "fill held", 32'(fill_valid), 1);
    chk("R4", "no output", 32'(out_valid), 0);
    @(negedge clk);
    fill_ready = 1'b1;
    after_edge();
    chk("R4", "single fill", 32'(fill_valid), 0);
    chk("R4", "still held", 32'(in_ready), 0);
    @(negedge clk);
    dc_hit = 1'b1; dc_data = 12'o0042;
    #1;
    chk("R4", "in_ready on hit", 32'(in_ready), 1);
    after_edge();
    chk("R4", "out_addr after fill", 32'(out_addr), 32'(15'o60042));
    @(negedge clk);
    in_valid = 1'b0;
    after_edge();

    // R6: store channel busy
    @(negedge clk);
    put('0, 1'b1, 1'b1, 15'o00021, 3'd4, 1'b1, 12'o0100);
    st_ready = 1'b0;
    #1;
    chk("R6", "in_ready", 32'(in_ready), 0);
    chk("R6", "st_valid", 32'(st_valid), 1);
    after_edge();
    chk("R6", "out_valid", 32'(out_valid), 0);
    @(negedge clk);
    st_ready = 1'b1;
    #1;
    chk("R6", "in_ready released", 32'(in_ready), 1);
    after_edge();
    chk("R6", "out_addr", 32'(out_addr), 32'(15'o40101));

    // R12: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    put('0, 1'b0, 1'b0, 15'o00007, 3'd0, 1'b1, '0);
    #1;
    chk("R12", "in_ready", 32'(in_ready), 0);
    after_edge();
    chk("R12", "out_valid held", 32'(out_valid), 1);
    chk("R12", "out_addr held", 32'(out_addr), 32'(15'o40101));
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk("R12", "in_ready on drain", 32'(in_ready), 1);
    after_edge();
    exp_cnt++;
    chk("R12", "next out_addr", 32'(out_addr), 32'(15'o00007));
    chk("R10", "store_cnt", 32'(store_cnt), 32'(exp_cnt));
    @(negedge clk);
    in_valid = 1'b0;
    after_edge();

    // R7: stale head
    @(negedge clk);
    put(2'd2, 1'b1, 1'b1, 15'o00055, 3'd1, 1'b1, 12'o0010);
    #1;
    chk("R7", "in_ready", 32'(in_ready), 1);
    chk("R7", "st_valid", 32'(st_valid), 0);
    chk("R7", "fill_valid", 32'(fill_valid), 0);
    after_edge();
    chk("R7", "out_valid", 32'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;

    // R8: generation acceptance and adoption
    @(negedge clk);
    core_gen = 2'd1;
    put(2'd0, 1'b0, 1'b0, 15'o00333, 3'd0, 1'b1, '0);
    #1;
    chk("R8", "stage-gen accepted", 32'(in_ready), 1);
    after_edge();
    chk("R8", "out_addr", 32'(out_addr), 32'(15'o00333));
    @(negedge clk);
    put(2'd1, 1'b0, 1'b0, 15'o00444, 3'd0, 1'b1, '0);
    after_edge();
    chk("R8", "core-gen out_addr", 32'(out_addr), 32'(15'o00444));
    @(negedge clk);
    put(2'd0, 1'b0, 1'b0, 15'o00555, 3'd0, 1'b1, '0);
    after_edge();
    chk("R8", "old tag squashed", 32'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;

    // R9 / R11: flush undoes a held auto-increment
    @(negedge clk);
    out_ready = 1'b0;
    put(2'd1, 1'b1, 1'b1, 15'o00044, 3'd2, 1'b1, 12'o0005);
    after_edge();
    chk("R9", "held out_addr", 32'(out_addr), 32'(15'o20006));
    @(negedge clk);
    in_valid = 1'b0; core_gen = 2'd2; flush = 1'b1; st_ready = 1'b0;
    #1;
    chk("R9", "live before flush edge", 32'(out_valid), 1);
    after_edge();
    chk("R9", "withdrawn", 32'(out_valid), 0);
    chk("R9", "undo st_valid", 32'(st_valid), 1);
    chk("R9", "undo st_addr", 32'(st_addr), 32'(15'o00044));
    chk("R9", "undo st_data", 32'(st_data), 32'(12'o0005));
    chk("R9", "undo mask", 32'(st_mask), 32'(8'b0001_0000));
    @(negedge clk);
    flush = 1'b0;
    after_edge();
    chk("R9", "undo waits", 32'(st_valid), 1);
    chk("R9", "cnt before undo", 32'(store_cnt), 32'(exp_cnt));
    @(negedge clk);
    st_ready = 1'b1;
    #1;
    chk("R11", "undo upd_valid", 32'(upd_valid), 1);
    chk("R11", "undo upd_data", 32'(upd_data), 32'(12'o0005));
    chk("R11", "undo upd_addr", 32'(upd_addr), 32'(15'o00044));
    after_edge();
    exp_cnt += 2;
    chk("R9", "undo done", 32'(st_valid), 0);
    chk("R9", "cnt plus two", 32'(store_cnt), 32'(exp_cnt));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule